// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM channel and walks the memory from power-up to a usable state. After reset it holds the device on no-operation with the clock enable high for a stabilization window. It then closes every bank with one precharge-all command and issues a fixed number of auto-refresh commands. Last, it loads the mode register and raises a sticky `done` once the mode-register-to-activate gap has passed. The data mask stays high throughout, so the memory never drives the data bus while the sequence runs. Every wait is given in nanoseconds and converted to a whole number of clock cycles at elaboration time, rounded up, with a floor of one cycle.

The controller is a single Moore state machine. Its states are HOLD (stabilization NOPs), PRECHARGE (precharge-all, then NOPs for the precharge time), REFRESH (one auto-refresh, then NOPs for the refresh cycle time, repeated), MODESET (mode-register load, then NOPs for the gap) and READY (done). It has four transitions. HOLD goes to PRECHARGE when the stabilization count ends. PRECHARGE goes to REFRESH when the precharge time ends. REFRESH stays in REFRESH while refreshes remain and goes to MODESET after the last one. MODESET goes to READY when the gap ends. READY is held until reset. Each command state issues its command in the first cycle it is entered and drives NOP for the rest of its stay. A shared cycle timer measures how long the machine stays in each state, and a second counter tallies the refreshes.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, and for STABLE_CYC = ceil(STABLE_NS/CLK_NS) cycles after release (cycles 0 to STABLE_CYC-1), the command is NOP: {cs_n,ras_n,cas_n,we_n} = 0111, with addr = 0 and done = 0.
- R2: In cycle STABLE_CYC the precharge-all command {cs_n,ras_n,cas_n,we_n} = 0010 is issued once, with addr bit 10 = 1 and every other addr bit 0.
- R3: The first command after the precharge-all comes exactly RP_CYC = ceil(TRP_NS/CLK_NS) cycles later, and only NOP is driven in between.
- R4: Exactly REFRESH_CNT auto-refresh commands (0001, addr = 0) are issued, RC_CYC = ceil(TRC_NS/CLK_NS) cycles apart, starting RP_CYC cycles after the precharge-all, and only NOP is driven between them.
- R5: The mode-set command (0000) is issued once, RC_CYC cycles after the last auto-refresh. addr[2:0] carries the burst length code, addr[3] the burst type (1 = interleaved), addr[6:4] the CAS latency code (010 = 2, 011 = 3), addr[9] the single-write flag, and every other addr bit is 0.
- R6: done rises exactly TMRD_CYC cycles after the mode-set command and stays high with NOP driven until the next reset.
- R7: cke and dqm are 1 in every cycle, including during reset.
- R8: Each nanosecond wait is rounded up to whole cycles, so a time that is not a multiple of CLK_NS takes the next larger cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| burst_len_code | input | 3 | Burst length code written to addr[2:0] |
| burst_interleave | input | 1 | Burst type written to addr[3] (1 = interleaved) |
| cas_lat_code | input | 3 | CAS latency code written to addr[6:4] |
| write_single | input | 1 | Single-write mode flag written to addr[9] |
| cke | output | 1 | Clock enable to the memory, always high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select, held at zero |
| addr | output | ADDR_W | Address lines: bit 10 for precharge-all, the mode word for mode-set |
| dqm | output | 1 | Data mask, held high so the data bus stays undriven |
| done | output | 1 | Sticky ready flag |

## Verification
The bench sweeps all 64 combinations of the mode fields. For each one it resets the block and compares the pins in every cycle against a schedule computed from the rounded waits. Wait times that are not multiples of the clock period catch truncation in place of rounding up. Such a design would issue the first refresh or a later command one cycle early. The bench also checks the boundary cycles, such as the last stabilization NOP, the cycle just before the first refresh and the cycle before done rises. A refresh counter that is off by one shows up as a seventh or ninth refresh and a mode-set that moves by RC_CYC cycles. A mode field at the wrong position shows up as a wrong address on the mode-set cycle for some of the combinations.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODESET  = 4'b0000,
        CMD_AUTOREF  = 4'b0001,
        CMD_PRE_ALL  = 4'b0010,
        CMD_NOP      = 4'b0111
    } boot_cmd_e;

    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_PRECHARGE = 3'd1,
        ST_REFRESH   = 3'd2,
        ST_MODESET   = 3'd3,
        ST_READY     = 3'd4
    } boot_state_e;

    // Nanoseconds to cycles, rounded up, never below one cycle
    function automatic int unsigned ns_to_cycles(input int unsigned ns_val,
                                                 input int unsigned clk_ns);
        int unsigned cyc;
        cyc = (ns_val + clk_ns - 1) / clk_ns;
        return (cyc == 0) ? 1 : cyc;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boot_counter.sv
module boot_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/boot_cmd_encode.sv
module boot_cmd_encode
    import sdram_boot_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 1
) (
    input  boot_cmd_e         cmd,
    input  logic [2:0]        burst_len_code,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_lat_code,
    input  logic              write_single,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] mode_word;

    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = burst_len_code;
        mode_word[3]   = burst_interleave;
        mode_word[6:4] = cas_lat_code;
        mode_word[9]   = write_single;
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign ba = '0;

    always_comb begin
        addr = '0;
        unique case (cmd)
            CMD_PRE_ALL: addr[10] = 1'b1;
            CMD_MODESET: addr     = mode_word;
            default:     addr     = '0;
        endcase
    end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int unsigned CLK_NS      = 4,
    parameter int unsigned STABLE_NS   = 200000,
    parameter int unsigned TRP_NS      = 20,
    parameter int unsigned TRC_NS      = 70,
    parameter int unsigned REFRESH_CNT = 8,
    parameter int unsigned TMRD_CYC    = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned BA_W        = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        burst_len_code,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_lat_code,
    input  logic              write_single,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dqm,
    output logic              done
);

    localparam int unsigned STABLE_CYC = ns_to_cycles(STABLE_NS, CLK_NS);
    localparam int unsigned RP_CYC     = ns_to_cycles(TRP_NS, CLK_NS);
    localparam int unsigned RC_CYC     = ns_to_cycles(TRC_NS, CLK_NS);
    localparam int unsigned MRD_CYC    = (TMRD_CYC == 0) ? 1 : TMRD_CYC;
    localparam int unsigned MAX_WAIT   = max2(max2(STABLE_CYC, RP_CYC), max2(RC_CYC, MRD_CYC));
    localparam int unsigned TMR_W      = $clog2(MAX_WAIT + 1);
    localparam int unsigned REF_W      = $clog2(REFRESH_CNT + 1);

    boot_state_e       state, state_nxt;
    boot_cmd_e         cur_cmd;
    logic [TMR_W-1:0]  tmr;
    logic [TMR_W-1:0]  stay_limit;
    logic [REF_W-1:0]  ref_cnt;
    logic              stay_last;
    logic              ref_bump;

    // Time spent in the current state
    boot_counter #(.W(TMR_W)) u_stay_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state != ST_READY),
        .clr   (stay_last),
        .cnt   (tmr)
    );

    assign ref_bump = (state == ST_REFRESH) && stay_last;

    boot_counter #(.W(REF_W)) u_ref_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ref_bump),
        .clr   (1'b0),
        .cnt   (ref_cnt)
    );

    always_comb begin
        unique case (state)
            ST_HOLD:      stay_limit = TMR_W'(STABLE_CYC);
            ST_PRECHARGE: stay_limit = TMR_W'(RP_CYC);
            ST_REFRESH:   stay_limit = TMR_W'(RC_CYC);
            ST_MODESET:   stay_limit = TMR_W'(MRD_CYC);
            default:      stay_limit = TMR_W'(1);
        endcase
    end

    assign stay_last = (tmr == stay_limit - 1'b1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD:      if (stay_last) state_nxt = ST_PRECHARGE;
            ST_PRECHARGE: if (stay_last) state_nxt = ST_REFRESH;
            ST_REFRESH: begin
                if (stay_last && (ref_cnt == REF_W'(REFRESH_CNT - 1))) begin
                    state_nxt = ST_MODESET;
                end
            end
            ST_MODESET:   if (stay_last) state_nxt = ST_READY;
            ST_READY:     state_nxt = ST_READY;
            default:      state_nxt = ST_HOLD;
        endcase
    end

    // Outputs: a command state fires in its first cycle, NOP afterwards
    always_comb begin
        cur_cmd = CMD_NOP;
        if (tmr == '0) begin
            unique case (state)
                ST_PRECHARGE: cur_cmd = CMD_PRE_ALL;
                ST_REFRESH:   cur_cmd = CMD_AUTOREF;
                ST_MODESET:   cur_cmd = CMD_MODESET;
                default:      cur_cmd = CMD_NOP;
            endcase
        end
    end

    assign cke  = 1'b1;
    assign dqm  = 1'b1;
    assign done = (state == ST_READY);

    boot_cmd_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .cmd              (cur_cmd),
        .burst_len_code   (burst_len_code),
        .burst_interleave (burst_interleave),
        .cas_lat_code     (cas_lat_code),
        .write_single     (write_single),
        .cs_n             (cs_n),
        .ras_n            (ras_n),
        .cas_n            (cas_n),
        .we_n             (we_n),
        .ba               (ba),
        .addr             (addr)
    );

endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dqm,
    input logic              done
);

    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    AST_CKE_DQM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cke && dqm); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R6

    AST_NOP_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pins == 4'b0111)); // R6

    AST_PALL_BIT10: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> (addr == (ADDR_W'(1) << 10))); // R2

    AST_MODESET_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> ((addr[8:7] == 2'b00) && ((addr >> 10) == '0))); // R5

    AST_NOP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != 4'b0111) |=> (pins == 4'b0111)); // R4

    AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0111) || (pins == 4'b0010) || (pins == 4'b0001) || (pins == 4'b0000)); // R3

    AST_NO_DONE_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pins == 4'b0111)); // R6

endmodule

bind sdram_boot_seq boot_seq_checker #(.ADDR_W(ADDR_W)) u_boot_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .addr  (addr),
    .dqm   (dqm),
    .done  (done)
);

// File: tb/sdram_boot_seq_test.sv
`timescale 1ns/1ps
module sdram_boot_seq_test;

    localparam int CLK_NS   = 4;
    localparam int STAB_NS  = 402;   // not a multiple of the clock: 101 cycles
    localparam int RP_NS    = 18;    // 5 cycles
    localparam int RC_NS    = 61;    // 16 cycles
    localparam int NREF     = 8;
    localparam int MRD      = 2;
    localparam int AW       = 12;

    // Expected cycle counts, rounded up (R8)
    localparam int S_CYC  = (STAB_NS + CLK_NS - 1) / CLK_NS;
    localparam int P_CYC  = (RP_NS + CLK_NS - 1) / CLK_NS;
    localparam int C_CYC  = (RC_NS + CLK_NS - 1) / CLK_NS;
    localparam int T_MRS  = S_CYC + P_CYC + NREF * C_CYC;
    localparam int T_DONE = T_MRS + MRD;
    localparam int T_END  = T_DONE + 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bl = '0;
    logic          bt = 1'b0;
    logic [2:0]    cl = '0;
    logic          sw = 1'b0;
    logic          cke, cs_n, ras_n, cas_n, we_n, dqm, done;
    logic [0:0]    ba;
    logic [AW-1:0] addr;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdram_boot_seq #(
        .CLK_NS(CLK_NS), .STABLE_NS(STAB_NS), .TRP_NS(RP_NS), .TRC_NS(RC_NS),
        .REFRESH_CNT(NREF), .TMRD_CYC(MRD), .ADDR_W(AW), .BA_W(1)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .burst_len_code(bl), .burst_interleave(bt), .cas_lat_code(cl), .write_single(sw),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .dqm(dqm), .done(done)
    );

    task automatic check(input string req, input int cyc,
                         input logic [3:0] exp_cmd, input logic [AW-1:0] exp_addr,
                         input logic exp_done);
        logic [AW+6:0] act, exp;
        act = {cs_n, ras_n, cas_n, we_n, addr, cke, dqm, done};
        exp = {exp_cmd, exp_addr, 1'b1, 1'b1, exp_done};
        vectors++;
        if (act !== exp || ba !== 1'b0) begin
            errors++;
            $display("FAIL %s cycle %0d mode=%0d/%0d/%0d/%0d actual=%h expected=%h",
                     req, cyc, bl, bt, cl, sw, act, exp);
        end
    endtask

    task automatic run_one();
        logic [AW-1:0] mw;
        mw = '0;
        mw[2:0] = bl; mw[3] = bt; mw[6:4] = cl; mw[9] = sw;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R1 reset", -1, 4'b0111, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c <= T_END; c++) begin
            #1;
            if (c < S_CYC)
                check("R1 hold", c, 4'b0111, '0, 1'b0);
            else if (c == S_CYC)
                check("R2 pall", c, 4'b0010, AW'(1) << 10, 1'b0);
            else if (c < S_CYC + P_CYC)
                check("R3 trp", c, 4'b0111, '0, 1'b0);
            else if (c < T_MRS) begin
                if (((c - S_CYC - P_CYC) % C_CYC) == 0)
                    check("R4 ref", c, 4'b0001, '0, 1'b0);
                else
                    check("R4 trc", c, 4'b0111, '0, 1'b0);
            end
            else if (c == T_MRS)
                check("R5 modeset", c, 4'b0000, mw, 1'b0);
            else if (c < T_DONE)
                check("R6 tmrd", c, 4'b0111, '0, 1'b0);
            else
                check("R6 R8 done", c, 4'b0111, '0, 1'b1);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int m = 0; m < 64; m++) begin
            @(negedge clk);
            bl = 3'(m & 7);
            bt = 1'((m >> 3) & 1);
            cl = ((m >> 4) & 1) != 0 ? 3'b011 : 3'b010;
            sw = 1'((m >> 5) & 1);
            run_one();
        end
        // R7: reset again mid-run restarts the hold with cke/dqm high
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R7 rerst", -1, 4'b0111, '0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog R6 actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule